// File: doc/BRIEF.md
# Lossless Float Narrowing Encoder

This block accepts a 64-bit binary64 bit pattern and returns the narrowest IEEE 754 interchange format that holds exactly the same value: binary16, binary32, or binary64 left unchanged. Nothing is ever rounded. When a narrower encoding would lose even one bit of magnitude, precision or NaN payload, the value leaves the block at the wider size with its bits untouched. A serializer that wants the shortest exact encoding of a floating-point number uses it to choose the float width before it writes the value out.

The work is split into two exact-narrowing steps built from one parameterized unit. The first step tries binary64 to binary32. The second step tries binary32 to binary16. It runs only on a successful first step, and only when the half-enable input was set with the sample. An optional register between the steps shortens the combinational path. An output register presents the result right-aligned in a 64-bit word, with a 2-bit size tag and a valid flag.

Top module: `fp_narrow_enc`

## Requirements
- R1: A zero of either sign narrows to a zero of the same sign in the narrowest permitted format: half when half is enabled, single otherwise.
- R2: A subnormal source is never narrowed. A binary64 subnormal leaves as binary64. A binary32 subnormal produced by the first step leaves as binary32 even when half is enabled.
- R3: An infinity of either sign always narrows to the target infinity, which has all exponent bits set and a zero fraction.
- R4: A NaN narrows only when the fraction bits the target cannot hold are all zero. These are the low 29 bits going to single and the low 13 bits going to half. The kept fraction bits are moved down into the target fraction. Any other NaN stays at its source size.
- R5: A normal value becomes a target normal when two conditions hold. Its unbiased exponent must be within -126..127 for single or -14..15 for half. Its dropped fraction bits must be zero. Values outside these conditions, such as 2^16 toward half or 2^128 toward single, are not narrowed to a normal.
- R6: A normal value becomes a target subnormal, with biased exponent 0, under two conditions. Its unbiased exponent must be within -127..-149 for single or -15..-24 for half. The significand with its hidden one must be shiftable right by (target minimum exponent − exponent) + (source fraction width − target fraction width) without discarding a set bit. Otherwise the value keeps the wider size.
- R7: The half step applies only when the first step succeeded and `half_en` was high with the sample. With `half_en` low, a value that fits half is output as single.
- R8: `out_size` is 2'b00 for half, 2'b01 for single and 2'b10 for double; the value 2'b11 never appears. The result is right-aligned in `out_bits` with every bit above the format width cleared.
- R9: With the default middle register, a sample accepted on a clock edge appears at the outputs two edges later, together with `out_valid`. Consecutive samples stream one per cycle. While `out_valid` is low, `out_bits` and `out_size` keep their last values. After reset, `out_valid` is low.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock, rising edge active |
| rst_n | input | 1 | Synchronous active-low reset |
| in_valid | input | 1 | Marks `in_bits` and `half_en` as a sample to convert |
| in_bits | input | 64 | binary64 bit pattern to narrow |
| half_en | input | 1 | Permits the second step to binary16 for this sample |
| out_valid | output | 1 | Result on `out_bits`/`out_size` is new this cycle |
| out_bits | output | 64 | Narrowed pattern, right-aligned, upper bits zero |
| out_size | output | 2 | Format of `out_bits`: 00 half, 01 single, 10 double |

## Verification
The bench targets the exponent edges where the two steps change behaviour: half's largest normal and 2^16, single's 2^127 and 2^128, and the subnormal floors 2^-149 and 2^-24 with their inexact neighbours. A design with an off-by-one range would narrow 2^16 or 2^-150 and so lose value, or it would leave 2^-24 at single. NaNs are tested with payload bits just inside and just outside each dropped field. A wrong mask would strip a payload, or it would refuse a quiet NaN that fits. Other tests cover signed zero, infinities, binary32 subnormals with half enabled, and half-disable. A design that skipped these would narrow a single subnormal to a half subnormal or ignore the enable. Timing tests check that back-to-back samples come out in order two cycles later and that the result holds once valid falls.

// File: rtl/fp_narrow_pkg.sv
// Package: shared format constants, the size tag encoding and the
// record carried between the two narrowing steps.
package fp_narrow_pkg;

    localparam int DBL_EXP  = 11;
    localparam int DBL_FRAC = 52;
    localparam int SGL_EXP  = 8;
    localparam int SGL_FRAC = 23;
    localparam int HLF_EXP  = 5;
    localparam int HLF_FRAC = 10;

    localparam int DBL_W = 1 + DBL_EXP + DBL_FRAC;
    localparam int SGL_W = 1 + SGL_EXP + SGL_FRAC;
    localparam int HLF_W = 1 + HLF_EXP + HLF_FRAC;

    typedef enum logic [1:0] {
        SZ_HALF   = 2'b00,
        SZ_SINGLE = 2'b01,
        SZ_DOUBLE = 2'b10
    } size_code_t;

    typedef struct packed {
        logic             vld;
        logic             hen;
        logic             sgl_ok;
        logic [SGL_W-1:0] sgl_bits;
        logic [DBL_W-1:0] src_bits;
    } mid_rec_t;

endpackage

// File: rtl/fp_narrow_step.sv
// Module: fp_narrow_step
// One exact narrowing step from a wider IEEE binary format to a narrower one.
// Assumes DST_EXP < SRC_EXP and DST_FRAC < SRC_FRAC. Purely combinational.
// fits=1 means dst_bits holds exactly the same value. With fits=0, dst_bits
// is don't-care.
module fp_narrow_step #(
    parameter int SRC_EXP  = 11,
    parameter int SRC_FRAC = 52,
    parameter int DST_EXP  = 8,
    parameter int DST_FRAC = 23
) (
    input  logic [SRC_EXP+SRC_FRAC:0] src_bits,
    output logic                      fits,
    output logic [DST_EXP+DST_FRAC:0] dst_bits
);
    localparam int SRC_W    = 1 + SRC_EXP + SRC_FRAC;
    localparam int DROP     = SRC_FRAC - DST_FRAC;
    localparam int SRC_BIAS = (1 << (SRC_EXP - 1)) - 1;
    localparam int DST_BIAS = (1 << (DST_EXP - 1)) - 1;
    localparam int DST_EMIN = 1 - DST_BIAS;
    localparam int DST_EMAX = DST_BIAS;

    logic                sgn;
    logic [SRC_EXP-1:0]  bexp;
    logic [SRC_FRAC-1:0] frac;
    logic [SRC_FRAC:0]   mant;
    logic [SRC_FRAC:0]   lost;
    logic [DST_FRAC-1:0] sub_frac;
    logic                tail_zero;
    int                  e_unb;
    int                  sh;

    // Purpose: split the source into fields and precompute the exactness tests.
    always_comb begin
        sgn       = src_bits[SRC_W-1];
        bexp      = src_bits[SRC_W-2 -: SRC_EXP];
        frac      = src_bits[SRC_FRAC-1:0];
        e_unb     = int'(bexp) - SRC_BIAS;
        tail_zero = (frac[DROP-1:0] == '0);
        mant      = {1'b1, frac};
        sh        = (DST_EMIN - e_unb) + DROP;
        lost      = mant & ~({(SRC_FRAC+1){1'b1}} << sh);
        sub_frac  = DST_FRAC'(mant >> sh);
    end

    // Purpose: choose the class of the value and build the narrowed pattern.
    always_comb begin
        fits     = 1'b0;
        dst_bits = '0;
        if (bexp == '0) begin
            fits     = (frac == '0);
            dst_bits = {sgn, {DST_EXP{1'b0}}, {DST_FRAC{1'b0}}};
        end else if (bexp == '1) begin
            fits     = (frac == '0) || tail_zero;
            dst_bits = {sgn, {DST_EXP{1'b1}}, frac[SRC_FRAC-1 -: DST_FRAC]};
        end else if (e_unb >= DST_EMIN && e_unb <= DST_EMAX && tail_zero) begin
            fits     = 1'b1;
            dst_bits = {sgn, DST_EXP'(e_unb + DST_BIAS), frac[SRC_FRAC-1 -: DST_FRAC]};
        end else if (e_unb < DST_EMIN && e_unb >= DST_EMIN - DST_FRAC && lost == '0) begin
            fits     = 1'b1;
            dst_bits = {sgn, {DST_EXP{1'b0}}, sub_frac};
        end
    end
endmodule

// File: rtl/fp_pipe_slot.sv
// Module: fp_pipe_slot
// Optional register stage. REGISTERED=1 inserts a flop that clears on
// synchronous active-low reset. REGISTERED=0 is a plain wire.
module fp_pipe_slot #(
    parameter int W          = 8,
    parameter bit REGISTERED = 1'b1
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic [W-1:0] d,
    output logic [W-1:0] q
);
    generate
        if (REGISTERED) begin : g_reg
            // Purpose: hold the stage record for one cycle.
            always_ff @(posedge clk) begin
                if (!rst_n) q <= '0;
                else        q <= d;
            end
        end else begin : g_wire
            assign q = d;
        end
    endgenerate
endmodule

// File: rtl/fp_narrow_enc.sv
// Module: fp_narrow_enc
// Top level. The first step narrows double to single. An optional middle
// register follows. The second step narrows single to half. A registered
// output stage selects the narrowest exact result. Latency is 1 + MID_REG
// cycles. The output holds its value while no sample arrives.
module fp_narrow_enc
    import fp_narrow_pkg::*;
#(
    parameter bit MID_REG = 1'b1
) (
    input  logic        clk,
    input  logic        rst_n,
    input  logic        in_valid,
    input  logic [63:0] in_bits,
    input  logic        half_en,
    output logic        out_valid,
    output logic [63:0] out_bits,
    output logic [1:0]  out_size
);
    localparam int REC_W = $bits(mid_rec_t);

    logic             s1_ok;
    logic [SGL_W-1:0] s1_bits;
    mid_rec_t         rec_d, rec_q;
    logic             s2_ok;
    logic [HLF_W-1:0] s2_bits;
    logic [63:0]      res_bits;
    size_code_t       res_size;

    fp_narrow_step #(
        .SRC_EXP(DBL_EXP), .SRC_FRAC(DBL_FRAC),
        .DST_EXP(SGL_EXP), .DST_FRAC(SGL_FRAC)
    ) u_d2s (
        .src_bits(in_bits),
        .fits    (s1_ok),
        .dst_bits(s1_bits)
    );

    // Purpose: gather the first-step result with its sample context.
    always_comb begin
        rec_d.vld      = in_valid;
        rec_d.hen      = half_en;
        rec_d.sgl_ok   = s1_ok;
        rec_d.sgl_bits = s1_bits;
        rec_d.src_bits = in_bits;
    end

    fp_pipe_slot #(.W(REC_W), .REGISTERED(MID_REG)) u_mid (
        .clk  (clk),
        .rst_n(rst_n),
        .d    (rec_d),
        .q    (rec_q)
    );

    fp_narrow_step #(
        .SRC_EXP(SGL_EXP), .SRC_FRAC(SGL_FRAC),
        .DST_EXP(HLF_EXP), .DST_FRAC(HLF_FRAC)
    ) u_s2h (
        .src_bits(rec_q.sgl_bits),
        .fits    (s2_ok),
        .dst_bits(s2_bits)
    );

    // Purpose: pick the narrowest exact encoding and right-align it.
    always_comb begin
        if (!rec_q.sgl_ok) begin
            res_bits = rec_q.src_bits;
            res_size = SZ_DOUBLE;
        end else if (rec_q.hen && s2_ok) begin
            res_bits = {{(64-HLF_W){1'b0}}, s2_bits};
            res_size = SZ_HALF;
        end else begin
            res_bits = {{(64-SGL_W){1'b0}}, rec_q.sgl_bits};
            res_size = SZ_SINGLE;
        end
    end

    // Purpose: register the result on a valid sample and hold it otherwise.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            out_valid <= 1'b0;
            out_bits  <= '0;
            out_size  <= SZ_DOUBLE;
        end else begin
            out_valid <= rec_q.vld;
            if (rec_q.vld) begin
                out_bits <= res_bits;
                out_size <= res_size;
            end
        end
    end
endmodule

// File: rtl/fp_narrow_enc_chk.sv
// Module: fp_narrow_enc_chk
// Port-level properties of the narrowing encoder, bound into every instance.
module fp_narrow_enc_chk (
    input logic        clk,
    input logic        rst_n,
    input logic        out_valid,
    input logic [63:0] out_bits,
    input logic [1:0]  out_size
);
    AST_SIZE_LEGAL: assert property (@(posedge clk) disable iff (!rst_n)
        out_valid |-> out_size != 2'b11); // R8

    AST_HALF_UPPER_CLEAR: assert property (@(posedge clk) disable iff (!rst_n)
        (out_valid && out_size == 2'b00) |-> out_bits[63:16] == '0); // R8

    AST_SINGLE_UPPER_CLEAR: assert property (@(posedge clk) disable iff (!rst_n)
        (out_valid && out_size == 2'b01) |-> out_bits[63:32] == '0); // R8

    AST_ZERO_NEVER_WIDE: assert property (@(posedge clk) disable iff (!rst_n)
        (out_valid && out_size == 2'b10) |-> out_bits[62:0] != '0); // R1

    AST_INF_NEVER_WIDE: assert property (@(posedge clk) disable iff (!rst_n)
        (out_valid && out_size == 2'b10) |-> !(out_bits[62:52] == 11'h7ff && out_bits[51:0] == '0)); // R3

    AST_IDLE_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
        !out_valid |-> ($stable(out_bits) && $stable(out_size))); // R9
endmodule

bind fp_narrow_enc fp_narrow_enc_chk u_chk (.*);

// File: tb/fp_narrow_enc_tb.sv
// Bench: directed scenarios, one task per requirement group.
module fp_narrow_enc_tb;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        in_valid = 1'b0;
    logic [63:0] in_bits = '0;
    logic        half_en = 1'b0;
    logic        out_valid;
    logic [63:0] out_bits;
    logic [1:0]  out_size;

    int n_cmp = 0;
    int n_bad = 0;
    bit done  = 1'b0;

    localparam logic [1:0] HALF = 2'b00, SINGLE = 2'b01, DOUBLE = 2'b10;

    fp_narrow_enc u_dut (
        .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .in_bits(in_bits),
        .half_en(half_en), .out_valid(out_valid), .out_bits(out_bits),
        .out_size(out_size)
    );

    always #10 clk = ~clk;

    task automatic check(input string tag, input logic [63:0] act, input logic [63:0] exp);
        n_cmp++;
        if (act !== exp) begin
            n_bad++;
            $display("FAIL %s actual=%h expected=%h", tag, act, exp);
        end
    endtask

    // One sample in, checked two edges later, at the falling edge.
    task automatic run_case(input string tag, input logic [63:0] src, input bit hen,
                            input logic [63:0] exp_bits, input logic [1:0] exp_sz);
        @(negedge clk);
        in_valid = 1'b1; in_bits = src; half_en = hen;
        @(negedge clk);
        in_valid = 1'b0; in_bits = '0; half_en = 1'b0;
        @(negedge clk);
        check({tag, " valid"}, 64'(out_valid), 64'd1);
        check({tag, " bits"}, out_bits, exp_bits);
        check({tag, " size"}, 64'(out_size), 64'(exp_sz));
    endtask

    task automatic t_reset;
        check("R9 reset valid", 64'(out_valid), 64'd0);
    endtask

    task automatic t_zero;
        run_case("R1 +0 half", 64'h0000000000000000, 1'b1, 64'h0000, HALF);
        run_case("R1 -0 single", 64'h8000000000000000, 1'b0, 64'h80000000, SINGLE);
        run_case("R1 -0 half", 64'h8000000000000000, 1'b1, 64'h8000, HALF);
    endtask

    task automatic t_subnormal_src;
        run_case("R2 dbl subnormal", 64'h0000000000000001, 1'b1, 64'h0000000000000001, DOUBLE);
        run_case("R2 sgl subnormal kept", 64'h36A0000000000000, 1'b1, 64'h00000001, SINGLE);
    endtask

    task automatic t_inf;
        run_case("R3 -inf half", 64'hFFF0000000000000, 1'b1, 64'hFC00, HALF);
        run_case("R3 +inf single", 64'h7FF0000000000000, 1'b0, 64'h7F800000, SINGLE);
    endtask

    task automatic t_nan;
        run_case("R4 quiet nan half", 64'h7FF8000000000000, 1'b1, 64'h7E00, HALF);
        run_case("R4 nan low bit kept", 64'h7FF0000000000001, 1'b1, 64'h7FF0000000000001, DOUBLE);
        run_case("R4 nan single only", 64'h7FF0000020000000, 1'b1, 64'h7F800001, SINGLE);
    endtask

    task automatic t_normal;
        run_case("R5 one half", 64'h3FF0000000000000, 1'b1, 64'h3C00, HALF);
        run_case("R5 half max", 64'h40EFFC0000000000, 1'b1, 64'h7BFF, HALF);
        run_case("R5 2^16 single", 64'h40F0000000000000, 1'b1, 64'h47800000, SINGLE);
        run_case("R5 half min normal", 64'h3F10000000000000, 1'b1, 64'h0400, HALF);
        run_case("R5 2^127 single", 64'h47E0000000000000, 1'b1, 64'h7F000000, SINGLE);
        run_case("R5 2^128 double", 64'h47F0000000000000, 1'b1, 64'h47F0000000000000, DOUBLE);
        run_case("R5 1+2^-23 single", 64'h3FF0000020000000, 1'b1, 64'h3F800001, SINGLE);
        run_case("R5 1+2^-24 double", 64'h3FF0000010000000, 1'b1, 64'h3FF0000010000000, DOUBLE);
    endtask

    task automatic t_subnormal_dst;
        run_case("R6 0.75*2^-126", 64'h3808000000000000, 1'b0, 64'h00600000, SINGLE);
        run_case("R6 2^-149", 64'h36A0000000000000, 1'b0, 64'h00000001, SINGLE);
        run_case("R6 2^-150 double", 64'h3690000000000000, 1'b1, 64'h3690000000000000, DOUBLE);
        run_case("R6 2^-24 half", 64'h3E70000000000000, 1'b1, 64'h0001, HALF);
        run_case("R6 2^-25 single", 64'h3E60000000000000, 1'b1, 64'h33000000, SINGLE);
        run_case("R6 1.5*2^-24 single", 64'h3E78000000000000, 1'b1, 64'h33C00000, SINGLE);
        run_case("R6 1.5*2^-23 half", 64'h3E88000000000000, 1'b1, 64'h0003, HALF);
    endtask

    task automatic t_half_enable;
        run_case("R7 one no half", 64'h3FF0000000000000, 1'b0, 64'h3F800000, SINGLE);
        run_case("R7 inf no half", 64'hFFF0000000000000, 1'b0, 64'hFF800000, SINGLE);
    endtask

    task automatic t_size_align;
        run_case("R8 neg half", 64'hC000000000000000, 1'b1, 64'hC000, HALF);
        check("R8 half upper clear", {48'h0, out_bits[63:16]}, 64'h0);
    endtask

    task automatic t_timing;
        logic [63:0] held;
        @(negedge clk);
        in_valid = 1'b1; in_bits = 64'h3FF0000000000000; half_en = 1'b1;
        @(negedge clk);
        in_valid = 1'b1; in_bits = 64'h47E0000000000000; half_en = 1'b1;
        check("R9 not early", 64'(out_valid), 64'd0);
        @(negedge clk);
        in_valid = 1'b0; in_bits = '0; half_en = 1'b0;
        check("R9 first valid", 64'(out_valid), 64'd1);
        check("R9 first bits", out_bits, 64'h3C00);
        @(negedge clk);
        check("R9 second valid", 64'(out_valid), 64'd1);
        check("R9 second bits", out_bits, 64'h7F000000);
        held = out_bits;
        @(negedge clk);
        check("R9 valid drops", 64'(out_valid), 64'd0);
        check("R9 hold bits", out_bits, held);
        check("R9 hold size", 64'(out_size), 64'(SINGLE));
    endtask

    initial begin
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        t_reset();
        t_zero();
        t_subnormal_src();
        t_inf();
        t_nan();
        t_normal();
        t_subnormal_dst();
        t_half_enable();
        t_size_align();
        t_timing();
        done = 1'b1;
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
        $finish;
    end

    initial begin
        repeat (20000) @(posedge clk);
        if (!done) begin
            n_cmp++;
            n_bad++;
            $display("FAIL watchdog actual=running expected=finished");
            $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
            $finish;
        end
    end
endmodule